// File: doc/BRIEF.md
# Debug Halt Control and Status Register

This block is a 32-bit memory-mapped register placed between a debug access path and a processor core. A single-cycle register-bus port carries reads and writes. A source flag on that port tells a debugger access from a core access. The block drives the core's debug controls: enable, halt request, single-step, interrupt mask and stall break. It also gathers live and sticky status from the core.

A write has effect only when its upper sixteen bits carry a fixed key. Any other key drops the whole word. Two status flags latch events until a read clears them. Debug enable answers only to the debugger. The halt, step and interrupt-mask controls reach the core only while debug is enabled. Step and interrupt mask accept new values only while the core reports that it is halted.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A write changes state only when wdata[31:26]=6'h28, wdata[25]=0, wdata[24]=0, wdata[23:20]=4'h5 and wdata[19:16]=4'hF, so the full upper half is 16'hA05F. With any other upper half, no bit of the register changes.
- R2: Read bit 25 is a sticky core-reset flag. It is set in every cycle where core_in_reset is 1. While the core stays held in reset, each read returns 1.
- R3: Read bit 24 is a sticky retire flag. It is set by a cycle in which core_retired is 1.
- R4: A read returns the flag values from before the access and clears bits 25 and 24 at that edge. If a setting event falls in the same cycle as the read, the read returns the old value and the flag is 1 afterwards.
- R5: Bit 0 (debug enable) changes only on a write with bus_from_dbg=1. A keyed write from the core leaves it unchanged and still applies the other fields.
- R6: While debug enable is 0, halt_req_o, step_o, mask_int_o and stall_brk_o are all 0, whatever bits 1, 2, 3 and 5 hold. While it is 1, each output follows its bit.
- R7: Bit 1 (halt) is set by a core_halt_evt pulse. It is cleared whenever core_in_reset is 1, and the core reset takes priority over the event.
- R8: A write of 1 to bit 5 (stall break) sets it only if bits 0 and 1 are both 1 before the write. Otherwise bit 5 keeps its value. A keyed write of 0 clears it.
- R9: Bits 2 (step) and 3 (interrupt mask) take written values only in a cycle where core_halted is 1. Otherwise they keep their values and the rest of the write is applied.
- R10: Read bit 19 equals core_lockup AND NOT core_halted.
- R11: Read bits 18, 17 and 16 show core_sleeping, core_halted and core_regrdy live.
- R12: After rst, control bits 0 to 5 and both sticky flags are 0. Bits 31:26, 23:20, 15:6 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_from_dbg | input | 1 | 1 = access comes from the debugger, 0 = from the core |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always presenting the current register image |
| core_in_reset | input | 1 | Core is held in reset |
| core_retired | input | 1 | An instruction completed this cycle |
| core_lockup | input | 1 | Core lockup condition present |
| core_sleeping | input | 1 | Core is sleeping |
| core_halted | input | 1 | Core is in debug halt state |
| core_regrdy | input | 1 | Last core-register transfer done |
| core_halt_evt | input | 1 | Core entered halt by itself (e.g. breakpoint) |
| dbg_en_o | output | 1 | Debug enable |
| halt_req_o | output | 1 | Gated halt request |
| step_o | output | 1 | Gated single-step |
| mask_int_o | output | 1 | Gated interrupt mask |
| stall_brk_o | output | 1 | Gated stall break |

## Verification
The bench builds the block with the default key parameters, 6'h28 for the top field and 4'h5 for the middle field. This lets it write the literal word 16'hA05F in the upper half and try one-field corruptions of that word. With those values, it can run every key mismatch case: a wrong top field, a sticky-bit position set to 1, and a nibble that is not all ones. It also checks clear-on-read against an event in the same cycle, and a core-sourced write that must leave debug enable alone.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned KEY_TOP_W = 6;
    localparam int unsigned KEY_MID_W = 4;
    localparam int unsigned N_STICKY  = 2;

    localparam int unsigned POS_DEN    = 0;
    localparam int unsigned POS_HALT   = 1;
    localparam int unsigned POS_STEP   = 2;
    localparam int unsigned POS_MASK   = 3;
    localparam int unsigned POS_STALL  = 5;
    localparam int unsigned POS_REGRDY = 16;
    localparam int unsigned POS_HALTED = 17;
    localparam int unsigned POS_SLEEP  = 18;
    localparam int unsigned POS_LOCKUP = 19;
    localparam int unsigned POS_MID_LO = 20;
    localparam int unsigned POS_RETIRE = 24;
    localparam int unsigned POS_RST    = 25;
    localparam int unsigned POS_TOP_LO = 26;
    localparam int unsigned POS_ONES_LO = 16;
    localparam int unsigned ONES_W      = 4;

    localparam int unsigned IDX_RETIRE = 0;
    localparam int unsigned IDX_RST    = 1;

    typedef struct packed {
        logic stall;
        logic mask;
        logic step;
        logic halt;
        logic den;
    } ctrl_t;

    typedef struct packed {
        logic lockup;
        logic sleeping;
        logic halted;
        logic regrdy;
    } live_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.den   = w[POS_DEN];
        c.halt  = w[POS_HALT];
        c.step  = w[POS_STEP];
        c.mask  = w[POS_MASK];
        c.stall = w[POS_STALL];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_image(
        input ctrl_t                c,
        input live_t                s,
        input logic [N_STICKY-1:0]  sticky
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_DEN]    = c.den;
        w[POS_HALT]   = c.halt;
        w[POS_STEP]   = c.step;
        w[POS_MASK]   = c.mask;
        w[POS_STALL]  = c.stall;
        w[POS_REGRDY] = s.regrdy;
        w[POS_HALTED] = s.halted;
        w[POS_SLEEP]  = s.sleeping;
        w[POS_LOCKUP] = s.lockup;
        w[POS_RETIRE] = sticky[IDX_RETIRE];
        w[POS_RST]    = sticky[IDX_RST];
        return w;
    endfunction

endpackage

// File: rtl/dhc_key_check.sv
module dhc_key_check
    import dbg_halt_pkg::*;
#(
    parameter logic [KEY_TOP_W-1:0] KEY_TOP = 6'h28,
    parameter logic [KEY_MID_W-1:0] KEY_MID = 4'h5
) (
    input  logic [REG_W-1:0] wdata,
    output logic             key_ok
);
    logic top_ok, mid_ok, zero_ok, ones_ok;

    always_comb begin
        top_ok  = (wdata[POS_TOP_LO +: KEY_TOP_W] == KEY_TOP);
        mid_ok  = (wdata[POS_MID_LO +: KEY_MID_W] == KEY_MID);
        zero_ok = ~wdata[POS_RST] & ~wdata[POS_RETIRE];
        ones_ok = &wdata[POS_ONES_LO +: ONES_W];
        key_ok  = top_ok & mid_ok & zero_ok & ones_ok;
    end
endmodule

// File: rtl/dhc_sticky.sv
module dhc_sticky #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic         rd_clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag[i] <= 1'b0;
            else if (set_evt[i])
                flag[i] <= 1'b1;
            else if (rd_clr)
                flag[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dhc_ctrl.sv
module dhc_ctrl
    import dbg_halt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ok,
    input  logic  from_dbg,
    input  ctrl_t req,
    input  logic  core_in_reset,
    input  logic  core_halted,
    input  logic  halt_evt,
    output ctrl_t cur
);
    ctrl_t nxt;
    logic  stall_allowed;

    always_comb begin
        nxt           = cur;
        stall_allowed = cur.den & cur.halt;
        if (wr_ok) begin
            if (from_dbg)
                nxt.den = req.den;
            nxt.halt = req.halt;
            if (core_halted) begin
                nxt.step = req.step;
                nxt.mask = req.mask;
            end
            if (!req.stall)
                nxt.stall = 1'b0;
            else if (stall_allowed)
                nxt.stall = 1'b1;
        end
        if (core_in_reset)
            nxt.halt = 1'b0;
        else if (halt_evt)
            nxt.halt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
    import dbg_halt_pkg::*;
#(
    parameter logic [KEY_TOP_W-1:0] KEY_TOP = 6'h28,
    parameter logic [KEY_MID_W-1:0] KEY_MID = 4'h5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_from_dbg,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             core_in_reset,
    input  logic             core_retired,
    input  logic             core_lockup,
    input  logic             core_sleeping,
    input  logic             core_halted,
    input  logic             core_regrdy,
    input  logic             core_halt_evt,
    output logic             dbg_en_o,
    output logic             halt_req_o,
    output logic             step_o,
    output logic             mask_int_o,
    output logic             stall_brk_o
);
    logic                key_ok;
    logic                wr_ok;
    logic                rd_hit;
    logic [N_STICKY-1:0] sticky_set;
    logic [N_STICKY-1:0] sticky_q;
    ctrl_t               ctrl_q;
    ctrl_t               ctrl_req;
    live_t               live;

    dhc_key_check #(
        .KEY_TOP (KEY_TOP),
        .KEY_MID (KEY_MID)
    ) u_key (
        .wdata  (bus_wdata),
        .key_ok (key_ok)
    );

    always_comb begin
        wr_ok                  = bus_sel & bus_wr & key_ok;
        rd_hit                 = bus_sel & ~bus_wr;
        ctrl_req               = ctrl_from_word(bus_wdata);
        sticky_set             = '0;
        sticky_set[IDX_RETIRE] = core_retired;
        sticky_set[IDX_RST]    = core_in_reset;
    end

    dhc_sticky #(.N(N_STICKY)) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_evt (sticky_set),
        .rd_clr  (rd_hit),
        .flag    (sticky_q)
    );

    dhc_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .wr_ok         (wr_ok),
        .from_dbg      (bus_from_dbg),
        .req           (ctrl_req),
        .core_in_reset (core_in_reset),
        .core_halted   (core_halted),
        .halt_evt      (core_halt_evt),
        .cur           (ctrl_q)
    );

    always_comb begin
        live.lockup   = core_lockup & ~core_halted;
        live.sleeping = core_sleeping;
        live.halted   = core_halted;
        live.regrdy   = core_regrdy;
        bus_rdata     = pack_image(ctrl_q, live, sticky_q);
        dbg_en_o      = ctrl_q.den;
        halt_req_o    = ctrl_q.den & ctrl_q.halt;
        step_o        = ctrl_q.den & ctrl_q.step;
        mask_int_o    = ctrl_q.den & ctrl_q.mask;
        stall_brk_o   = ctrl_q.den & ctrl_q.stall;
    end
endmodule

// File: rtl/dhc_checker.sv
module dhc_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic        bus_from_dbg,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        core_in_reset,
    input logic        core_retired,
    input logic        core_lockup,
    input logic        core_sleeping,
    input logic        core_halted,
    input logic        core_regrdy,
    input logic        core_halt_evt,
    input logic        dbg_en_o,
    input logic        halt_req_o,
    input logic        step_o,
    input logic        mask_int_o,
    input logic        stall_brk_o
);
    logic bad_wr;
    assign bad_wr = bus_sel && bus_wr && (bus_wdata[31:16] != 16'hA05F);

    assert_bad_key_R1: assert property (@(posedge clk) disable iff (rst)
        (bad_wr && !core_in_reset && !core_halt_evt) |=> $stable(bus_rdata[5:0]));

    assert_rst_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        core_in_reset |=> bus_rdata[25]);

    assert_retire_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        core_retired |=> bus_rdata[24]);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !core_retired) |=> !bus_rdata[24]);

    assert_core_no_den_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !bus_from_dbg) |=> $stable(dbg_en_o));

    assert_gated_R6: assert property (@(posedge clk) disable iff (rst)
        !dbg_en_o |-> !(halt_req_o || step_o || mask_int_o || stall_brk_o));

    assert_halt_evt_R7: assert property (@(posedge clk) disable iff (rst)
        (core_halt_evt && !core_in_reset) |=> bus_rdata[1]);

    assert_halt_clr_R7: assert property (@(posedge clk) disable iff (rst)
        core_in_reset |=> !bus_rdata[1]);

    assert_stall_set_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rdata[5]) |-> $past(bus_rdata[1] && bus_rdata[0]));

    assert_step_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !core_halted |=> $stable(bus_rdata[3:2]));

    assert_lockup_R10: assert property (@(posedge clk) disable iff (rst)
        core_halted |-> !bus_rdata[19]);

    assert_por_R12: assert property (@(posedge clk)
        $past(rst) |-> (bus_rdata[5:0] == 6'd0 && bus_rdata[25:24] == 2'b00));
endmodule

bind dbg_halt_ctl dhc_checker u_dhc_checker (
    .clk           (clk),
    .rst           (rst),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_from_dbg  (bus_from_dbg),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .core_in_reset (core_in_reset),
    .core_retired  (core_retired),
    .core_lockup   (core_lockup),
    .core_sleeping (core_sleeping),
    .core_halted   (core_halted),
    .core_regrdy   (core_regrdy),
    .core_halt_evt (core_halt_evt),
    .dbg_en_o      (dbg_en_o),
    .halt_req_o    (halt_req_o),
    .step_o        (step_o),
    .mask_int_o    (mask_int_o),
    .stall_brk_o   (stall_brk_o)
);

// File: tb/test_dbg_halt_ctl.sv
module test_dbg_halt_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_from_dbg = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_in_reset = 1'b0, core_retired = 1'b0, core_lockup = 1'b0;
    logic        core_sleeping = 1'b0, core_halted = 1'b0, core_regrdy = 1'b0;
    logic        core_halt_evt = 1'b0;
    logic        dbg_en_o, halt_req_o, step_o, mask_int_o, stall_brk_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    localparam logic [31:0] KEY = 32'hA05F0000;

    always #2.5 clk = ~clk;

    dbg_halt_ctl i_dbg_halt_ctl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_from_dbg(bus_from_dbg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_in_reset(core_in_reset), .core_retired(core_retired),
        .core_lockup(core_lockup), .core_sleeping(core_sleeping),
        .core_halted(core_halted), .core_regrdy(core_regrdy),
        .core_halt_evt(core_halt_evt), .dbg_en_o(dbg_en_o),
        .halt_req_o(halt_req_o), .step_o(step_o), .mask_int_o(mask_int_o),
        .stall_brk_o(stall_brk_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d, input bit dbg);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d; bus_from_dbg = dbg;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_from_dbg = 1'b0;
    endtask

    task automatic bus_read(output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic outs_chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {stall_brk_o, mask_int_o, step_o, halt_req_o, dbg_en_o};
        check(act == exp, req, {27'd0, act}, {27'd0, exp});
    endtask

    task automatic t_reset_state;
        #1;
        check(bus_rdata == 32'd0, "R12 reset image", bus_rdata, 32'd0);
        outs_chk("R12 reset outputs", 5'b00000);
    endtask

    task automatic t_key;
        bus_write(KEY | 32'h3, 1'b1);
        #1 check(bus_rdata[5:0] == 6'h03, "R1 keyed write", {26'd0, bus_rdata[5:0]}, 32'h3);
        bus_write(32'hA05E0000, 1'b1);
        #1 check(bus_rdata[5:0] == 6'h03, "R1 bad ones nibble", {26'd0, bus_rdata[5:0]}, 32'h3);
        bus_write(32'hA25F0000, 1'b1);
        #1 check(bus_rdata[5:0] == 6'h03, "R1 bit25 set", {26'd0, bus_rdata[5:0]}, 32'h3);
        bus_write(32'hA45F0000, 1'b1);
        #1 check(bus_rdata[5:0] == 6'h03, "R1 bad top field", {26'd0, bus_rdata[5:0]}, 32'h3);
    endtask

    task automatic t_core_write;
        bus_write(KEY, 1'b0);
        #1 check(bus_rdata[1:0] == 2'b01, "R5 core write keeps den, clears halt",
                 {30'd0, bus_rdata[1:0]}, 32'h1);
        bus_write(KEY, 1'b1);
        #1 check(bus_rdata[0] == 1'b0, "R5 debugger clears den", {31'd0, bus_rdata[0]}, 32'h0);
    endtask

    task automatic t_gating;
        core_halted = 1'b1;
        bus_write(KEY | 32'hE, 1'b1);
        #1 check(bus_rdata[3:0] == 4'hE, "R6 bits stored", {28'd0, bus_rdata[3:0]}, 32'hE);
        outs_chk("R6 outputs gated off", 5'b00000);
    endtask

    task automatic t_step_mask;
        core_halted = 1'b0;
        bus_write(KEY | 32'h3, 1'b1);
        #1 check(bus_rdata[3:0] == 4'hF, "R9 step/mask held, rest applied",
                 {28'd0, bus_rdata[3:0]}, 32'hF);
        outs_chk("R6 outputs follow when enabled", 5'b01111);
        core_halted = 1'b1;
        bus_write(KEY | 32'h3, 1'b1);
        #1 check(bus_rdata[3:0] == 4'h3, "R9 step/mask written while halted",
                 {28'd0, bus_rdata[3:0]}, 32'h3);
    endtask

    task automatic t_stall;
        bus_write(KEY | 32'h23, 1'b1);
        #1 check(bus_rdata[5] == 1'b1, "R8 stall set when den&halt", {31'd0, bus_rdata[5]}, 32'h1);
        outs_chk("R8 stall output", 5'b10011);
        bus_write(KEY | 32'h1, 1'b1);
        #1 check(bus_rdata[5] == 1'b0, "R8 stall cleared", {31'd0, bus_rdata[5]}, 32'h0);
        bus_write(KEY | 32'h21, 1'b1);
        #1 check(bus_rdata[5] == 1'b0, "R8 stall ignored without halt", {31'd0, bus_rdata[5]}, 32'h0);
    endtask

    task automatic t_halt_evt;
        pulse(core_halt_evt);
        #1 check(bus_rdata[1] == 1'b1, "R7 halt event sets halt", {31'd0, bus_rdata[1]}, 32'h1);
        outs_chk("R7 halt request out", 5'b00011);
    endtask

    task automatic t_reset_sticky;
        logic [31:0] r;
        bus_read(r);
        pulse(core_in_reset);
        #1 check(bus_rdata[1] == 1'b0, "R7 core reset clears halt", {31'd0, bus_rdata[1]}, 32'h0);
        bus_read(r);
        check(r[25] == 1'b1, "R2 reset flag after pulse", {31'd0, r[25]}, 32'h1);
        bus_read(r);
        check(r[25] == 1'b0, "R4 reset flag cleared by read", {31'd0, r[25]}, 32'h0);
        @(negedge clk) core_in_reset = 1'b1;
        bus_read(r);
        check(r[25] == 1'b1, "R2 held reset read 1", {31'd0, r[25]}, 32'h1);
        bus_read(r);
        check(r[25] == 1'b1, "R2 held reset read 2", {31'd0, r[25]}, 32'h1);
        @(negedge clk) core_in_reset = 1'b0;
        bus_read(r);
        bus_read(r);
        check(r[25] == 1'b0, "R4 reset flag clear after release", {31'd0, r[25]}, 32'h0);
    endtask

    task automatic t_retire;
        logic [31:0] r;
        pulse(core_retired);
        bus_read(r);
        check(r[24] == 1'b1, "R3 retire flag set", {31'd0, r[24]}, 32'h1);
        bus_read(r);
        check(r[24] == 1'b0, "R4 retire cleared by read", {31'd0, r[24]}, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; core_retired = 1'b1;
        #1 r = bus_rdata;
        check(r[24] == 1'b0, "R4 same-cycle read returns old", {31'd0, r[24]}, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0; core_retired = 1'b0;
        bus_read(r);
        check(r[24] == 1'b1, "R4 same-cycle event survives", {31'd0, r[24]}, 32'h1);
    endtask

    task automatic t_live;
        @(negedge clk);
        core_halted = 1'b0; core_lockup = 1'b1; core_sleeping = 1'b1; core_regrdy = 1'b1;
        #1 check(bus_rdata[19:16] == 4'b1101, "R10 R11 lockup while running",
                 {28'd0, bus_rdata[19:16]}, 32'hD);
        core_halted = 1'b1; core_sleeping = 1'b0; core_regrdy = 1'b0;
        #1 check(bus_rdata[19:16] == 4'b0010, "R10 R11 lockup hidden when halted",
                 {28'd0, bus_rdata[19:16]}, 32'h2);
        check((bus_rdata & 32'hFCF0FFD0) == 32'd0, "R12 reserved bits zero",
              bus_rdata & 32'hFCF0FFD0, 32'd0);
        @(negedge clk);
        core_lockup = 1'b0; core_halted = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_key();
        t_core_write();
        t_gating();
        t_step_mask();
        t_stall();
        t_halt_evt();
        t_reset_sticky();
        t_retire();
        t_live();
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule